// File: doc/BRIEF.md
# Oscillator Trim Frequency Correction Loop

This block keeps a fast on-chip oscillator on frequency by comparing it against a slow reference clock. The reference is brought into the fast clock domain through a flop synchroniser with rising-edge detection. The block counts fast-clock cycles over one full reference period, from one synchronised rising edge to the next. It then checks that count against a programmable window with an inclusive lower and upper bound. If the count is above the window, the 7-bit trim code steps down by one. If it is below, the code steps up by one. If it is inside, the code holds. The code never wraps past either end of its range.

Software drives the loop through a small control write: a run bit, a mode bit and an interrupt-enable bit, all loaded together on one strobe. In continuous mode the closing edge of each window also opens the next one, and the loop runs until software clears the run bit. In single-pass mode the block makes one measurement and one correction, then clears its own run bit. The running count is visible on an output while it climbs. When interrupts are enabled, a one-cycle pulse marks every completed correction.

Top module: `osc_trim_loop`

## Requirements
- R1: After reset the trim code is 0, the live count is 0, the run readback is 0 and the interrupt output is low.
- R2: A control write with the run bit set makes `run_o` read 1 from the next cycle. The first window opens at the next synchronised reference rising edge. A write with the run bit clear makes `run_o` read 0.
- R3: The window count equals the number of fast-clock cycles between two consecutive synchronised reference rising edges. `live_count` reads 1 in the first cycle of a window and rises by exactly one per cycle after that.
- R4: When a window closes, a count above `hi_bound` steps the trim code down by 1. Otherwise a count below `lo_bound` steps it up by 1. A count equal to either bound, or between them, leaves the code unchanged. When `lo_bound` > `hi_bound`, a count above `hi_bound` takes the downward step.
- R5: The trim code saturates: a downward step at 0 leaves it at 0, and an upward step at 127 leaves it at 127.
- R6: With the interrupt-enable bit at 1, `done_irq` is high for exactly one fast-clock cycle after each correction, in the first cycle that shows the new trim code. With the bit at 0, no pulse is produced, but the correction still takes place.
- R7: With the mode bit at 0 (continuous), the edge that closes a window opens the next one, so `live_count` reads 1 in the cycle of the interrupt pulse. Corrections repeat once per reference period until the loop is stopped.
- R8: With the mode bit at 1 (single pass), exactly one window is measured and corrected. `run_o` then returns to 0 by itself, and `live_count` keeps the final count.
- R9: The window counter saturates at its all-ones value (2^CNT_W - 1, 20 bits by default) instead of wrapping.
- R10: Clearing the run bit during a window abandons that window. The trim code stays unchanged and no interrupt follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | Slow reference clock, asynchronous to clk |
| ctl_wr | input | 1 | Strobe loading the three control bits |
| ctl_run | input | 1 | Run bit: 1 starts, 0 stops |
| ctl_mode | input | 1 | Mode bit: 0 continuous, 1 single pass |
| ctl_ie | input | 1 | Interrupt enable |
| lo_bound | input | CNT_W (20) | Lowest count that counts as in range |
| hi_bound | input | CNT_W (20) | Highest count that counts as in range |
| run_o | output | 1 | Readback of the run bit |
| trim_code | output | TRIM_W (7) | Trim code for the oscillator |
| live_count | output | CNT_W (20) | Current window count |
| done_irq | output | 1 | One-cycle correction-complete pulse |

## Verification
The bench aims at counts that land exactly on `lo_bound` and on `hi_bound`. A design using strict comparisons would step the code where it should hold. It drives the code against both ends of its range, where a wrapping design would jump from 127 to 0 or from 0 to 127. It checks the window length against the reference period, since an off-by-one in the synchronised edge handling shows up as a count that is one too high or too low and turns a hold into a step. It also covers a window aborted halfway, a single pass with interrupts disabled, and a narrow counter instance held over a long window. A faulty design in those cases would change the trim, pulse the interrupt, leave `run_o` set, or let the count wrap back to small values.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_MEAS = 2'd2
    } loop_state_e;

    typedef enum logic [1:0] {
        VERDICT_HOLD = 2'd0,
        VERDICT_UP   = 2'd1,
        VERDICT_DOWN = 2'd2
    } verdict_e;

    typedef struct packed {
        logic run;
        logic single;
        logic irq_en;
    } ctl_s;

    // Above the window wins over below it, so a crossed window steps down.
    function automatic verdict_e judge(input logic [31:0] cnt,
                                       input logic [31:0] lo,
                                       input logic [31:0] hi);
        if (cnt > hi)
            return VERDICT_DOWN;
        else if (cnt < lo)
            return VERDICT_UP;
        else
            return VERDICT_HOLD;
    endfunction

endpackage

// File: rtl/ots_ref_sync.sv
module ots_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] chain;

    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    // Last synchronised stage against its one-cycle history.
    assign rise = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/ots_meas_cnt.sv
module ots_meas_cnt #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load_one,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (load_one)
            cnt <= CNT_ONE;
        else if (inc && cnt != CNT_MAX)
            cnt <= cnt + CNT_ONE;
    end

endmodule

// File: rtl/ots_trim_step.sv
module ots_trim_step
    import osc_trim_pkg::*;
#(
    parameter int TRIM_W = 7
) (
    input  logic [TRIM_W-1:0] cur,
    input  verdict_e          verdict,
    output logic [TRIM_W-1:0] nxt
);
    localparam logic [TRIM_W-1:0] TRIM_TOP = '1;
    localparam logic [TRIM_W-1:0] TRIM_ONE = TRIM_W'(1);

    always_comb begin
        unique case (verdict)
            VERDICT_UP:   nxt = (cur == TRIM_TOP) ? cur : cur + TRIM_ONE;
            VERDICT_DOWN: nxt = (cur == '0)       ? cur : cur - TRIM_ONE;
            default:      nxt = cur;
        endcase
    end

endmodule

// File: rtl/osc_trim_loop.sv
module osc_trim_loop
    import osc_trim_pkg::*;
#(
    parameter int TRIM_W      = 7,
    parameter int CNT_W       = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_clk,
    input  logic              ctl_wr,
    input  logic              ctl_run,
    input  logic              ctl_mode,
    input  logic              ctl_ie,
    input  logic [CNT_W-1:0]  lo_bound,
    input  logic [CNT_W-1:0]  hi_bound,
    output logic              run_o,
    output logic [TRIM_W-1:0] trim_code,
    output logic [CNT_W-1:0]  live_count,
    output logic              done_irq
);
    loop_state_e       state_q;
    ctl_s              ctl_q;
    logic              ref_rise;
    logic              start_req;
    logic              cnt_clear, cnt_load, cnt_inc;
    logic              window_end;
    verdict_e          verdict;
    logic [TRIM_W-1:0] trim_q, trim_nxt;

    ots_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ref_clk),
        .rise     (ref_rise)
    );

    // A write takes priority over a reference edge in the same cycle.
    assign start_req  = ctl_wr && ctl_run && !ctl_q.run;
    assign window_end = !ctl_wr && state_q == ST_MEAS && ref_rise;

    assign cnt_clear = start_req;
    assign cnt_load  = !ctl_wr && ref_rise &&
                       (state_q == ST_ARM || (state_q == ST_MEAS && !ctl_q.single));
    assign cnt_inc   = !ctl_wr && state_q == ST_MEAS && !ref_rise;

    ots_meas_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clear    (cnt_clear),
        .load_one (cnt_load),
        .inc      (cnt_inc),
        .cnt      (live_count)
    );

    assign verdict = judge(32'(live_count), 32'(lo_bound), 32'(hi_bound));

    ots_trim_step #(.TRIM_W(TRIM_W)) u_step (
        .cur     (trim_q),
        .verdict (verdict),
        .nxt     (trim_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            ctl_q    <= '0;
            trim_q   <= '0;
            done_irq <= 1'b0;
        end else begin
            done_irq <= 1'b0;
            if (ctl_wr) begin
                ctl_q.run    <= ctl_run;
                ctl_q.single <= ctl_mode;
                ctl_q.irq_en <= ctl_ie;
                if (!ctl_run)
                    state_q <= ST_IDLE;
                else if (start_req)
                    state_q <= ST_ARM;
            end else begin
                unique case (state_q)
                    ST_ARM: begin
                        if (ref_rise)
                            state_q <= ST_MEAS;
                    end
                    ST_MEAS: begin
                        if (window_end) begin
                            trim_q   <= trim_nxt;
                            done_irq <= ctl_q.irq_en;
                            if (ctl_q.single) begin
                                ctl_q.run <= 1'b0;
                                state_q   <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign run_o     = ctl_q.run;
    assign trim_code = trim_q;

endmodule

// File: rtl/osc_trim_chk.sv
module osc_trim_chk
    import osc_trim_pkg::*;
#(
    parameter int TRIM_W = 7,
    parameter int CNT_W  = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              done_irq,
    input logic              run_o,
    input logic              mode_q,
    input logic              ie_q,
    input loop_state_e       state_q,
    input logic [TRIM_W-1:0] trim_code,
    input logic [CNT_W-1:0]  live_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    p_irq_single_r6: assert property (@(posedge clk) disable iff (rst)
        done_irq |=> !done_irq);

    p_irq_enabled_r6: assert property (@(posedge clk) disable iff (rst)
        done_irq |-> ie_q);

    p_trim_unit_step_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ({1'b0, trim_code} == {1'b0, $past(trim_code)} ||
                  {1'b0, trim_code} == {1'b0, $past(trim_code)} + 1'b1 ||
                  {1'b0, trim_code} + 1'b1 == {1'b0, $past(trim_code)}));

    p_trim_from_window_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(trim_code) |-> $past(state_q == ST_MEAS));

    p_single_stops_r8: assert property (@(posedge clk) disable iff (rst)
        (done_irq && mode_q) |-> !run_o);

    p_cnt_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MEAS && live_count == CNT_MAX) |=>
            (live_count == CNT_MAX || live_count == CNT_ONE));

endmodule

bind osc_trim_loop osc_trim_chk #(.TRIM_W(TRIM_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .done_irq   (done_irq),
    .run_o      (run_o),
    .mode_q     (ctl_q.single),
    .ie_q       (ctl_q.irq_en),
    .state_q    (state_q),
    .trim_code  (trim_code),
    .live_count (live_count)
);

// File: tb/test_osc_trim_loop.sv
module test_osc_trim_loop;

    localparam int CNT_W   = 20;
    localparam int TRIM_W  = 7;
    localparam int SMALL_W = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_clk = 1'b0;
    logic ctl_wr = 1'b0, ctl_run = 1'b0, ctl_mode = 1'b0, ctl_ie = 1'b0;
    logic [CNT_W-1:0]  lo_bound = '0, hi_bound = '0;
    logic              run_o, done_irq;
    logic [TRIM_W-1:0] trim_code;
    logic [CNT_W-1:0]  live_count;
    logic              s_run, s_irq;
    logic [TRIM_W-1:0] s_trim;
    logic [SMALL_W-1:0] s_count;

    int total = 0;
    int bad = 0;
    int ref_per = 0;
    int tr_exp = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    osc_trim_loop #(.TRIM_W(TRIM_W), .CNT_W(CNT_W)) i_osc_trim_loop (
        .clk(clk), .rst(rst), .ref_clk(ref_clk),
        .ctl_wr(ctl_wr), .ctl_run(ctl_run), .ctl_mode(ctl_mode), .ctl_ie(ctl_ie),
        .lo_bound(lo_bound), .hi_bound(hi_bound),
        .run_o(run_o), .trim_code(trim_code), .live_count(live_count), .done_irq(done_irq)
    );

    osc_trim_loop #(.TRIM_W(TRIM_W), .CNT_W(SMALL_W)) i_small (
        .clk(clk), .rst(rst), .ref_clk(ref_clk),
        .ctl_wr(ctl_wr), .ctl_run(ctl_run), .ctl_mode(ctl_mode), .ctl_ie(ctl_ie),
        .lo_bound(lo_bound[SMALL_W-1:0]), .hi_bound(hi_bound[SMALL_W-1:0]),
        .run_o(s_run), .trim_code(s_trim), .live_count(s_count), .done_irq(s_irq)
    );

    // Reference generator: period in fast-clock cycles, driven off the falling edge.
    initial begin
        forever begin
            if (ref_per >= 2) begin
                ref_clk = 1'b1;
                repeat (ref_per / 2) @(negedge clk);
                ref_clk = 1'b0;
                repeat (ref_per - ref_per / 2) @(negedge clk);
            end else begin
                ref_clk = 1'b0;
                @(negedge clk);
            end
        end
    end

    function automatic int model_step(int tr, int cnt, int lo, int hi);
        if (cnt > hi)      return (tr == 0)   ? 0   : tr - 1;
        else if (cnt < lo) return (tr == 127) ? 127 : tr + 1;
        else               return tr;
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ctl(bit run, bit mode, bit ie);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_run = run; ctl_mode = mode; ctl_ie = ie;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic setup(int p, int lo, int hi);
        ref_per  = p;
        lo_bound = CNT_W'(lo);
        hi_bound = CNT_W'(hi);
        repeat (450) @(negedge clk);
    endtask

    task automatic wait_irq(int lim, output bit got);
        got = 1'b0;
        for (int i = 0; i < lim && !got; i++) begin
            @(negedge clk);
            if (done_irq) got = 1'b1;
        end
    endtask

    // Continuous mode, n windows of period p, every correction checked.
    task automatic cont_windows(int p, int lo, int hi, int n, string req);
        bit got;
        setup(p, lo, hi);
        ctl(1'b1, 1'b0, 1'b1);
        chk("R2 run readback", int'(run_o), 1);
        for (int w = 0; w < n; w++) begin
            wait_irq(3 * p + 20, got);
            chk({req, " R6 irq seen"}, int'(got), 1);
            tr_exp = model_step(tr_exp, p, lo, hi);
            chk({req, " trim"}, int'(trim_code), tr_exp);
            chk("R7 next window opened", int'(live_count), 1);
            @(negedge clk);
            chk("R6 pulse width", int'(done_irq), 0);
        end
        ctl(1'b0, 1'b0, 1'b1);
        chk("R2 stop readback", int'(run_o), 0);
    endtask

    initial begin
        bit got;
        int seen;
        int c1;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        chk("R1 trim", int'(trim_code), 0);
        chk("R1 count", int'(live_count), 0);
        chk("R1 run", int'(run_o), 0);
        chk("R1 irq", int'(done_irq), 0);
        rst = 1'b0;

        // R4 inclusive bounds and branches, R3 count equals period
        cont_windows(32, 32, 40, 2, "R3 R4 count on lower bound holds");
        cont_windows(32, 20, 32, 2, "R3 R4 count on upper bound holds");
        cont_windows(32, 33, 40, 2, "R3 R4 one below lower steps up");
        cont_windows(32, 10, 31, 2, "R3 R4 one above upper steps down");
        cont_windows(30, 40, 20, 1, "R4 crossed window steps down");

        // R5 saturation at both ends
        cont_windows(16, 1000, 2000, 135, "R5 climb");
        chk("R5 top saturated", int'(trim_code), 127);
        cont_windows(16, 0, 2, 135, "R5 descend");
        chk("R5 bottom saturated", int'(trim_code), 0);

        // Random windows against the model
        for (int k = 0; k < 30; k++) begin
            int p, lo, hi;
            p  = 16 + int'($urandom % 60);
            lo = 16 + int'($urandom % 50);
            hi = lo + int'($urandom % 12);
            cont_windows(p, lo, hi, 3, "R4 random");
        end

        // R8 single pass
        setup(30, 0, 10);
        ctl(1'b1, 1'b1, 1'b1);
        wait_irq(3 * 30 + 20, got);
        chk("R8 irq seen", int'(got), 1);
        tr_exp = model_step(tr_exp, 30, 0, 10);
        chk("R8 trim", int'(trim_code), tr_exp);
        chk("R8 run cleared", int'(run_o), 0);
        chk("R8 count kept", int'(live_count), 30);
        seen = 0;
        repeat (120) begin
            @(negedge clk);
            if (done_irq) seen++;
        end
        chk("R8 single pass only", seen, 0);
        chk("R8 trim unchanged after", int'(trim_code), tr_exp);
        chk("R8 count still kept", int'(live_count), 30);

        // R6 interrupt disabled: correction still happens, no pulse
        setup(30, 50, 60);
        ctl(1'b1, 1'b1, 1'b0);
        seen = 0;
        for (int i = 0; i < 200 && run_o; i++) begin
            @(negedge clk);
            if (done_irq) seen++;
        end
        chk("R6 no pulse with enable off", seen, 0);
        chk("R6 run cleared", int'(run_o), 0);
        tr_exp = model_step(tr_exp, 30, 50, 60);
        chk("R6 trim stepped without pulse", int'(trim_code), tr_exp);

        // R10 abort mid-window
        setup(40, 0, 5);
        ctl(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 200 && live_count != 10; i++) @(negedge clk);
        chk("R3 count visible mid-window", int'(live_count), 10);
        @(negedge clk);
        chk("R3 count advances by one", int'(live_count), 11);
        ctl(1'b0, 1'b0, 1'b1);
        seen = 0;
        repeat (150) begin
            @(negedge clk);
            if (done_irq) seen++;
        end
        chk("R10 no irq after abort", seen, 0);
        chk("R10 trim unchanged", int'(trim_code), tr_exp);
        chk("R10 run cleared", int'(run_o), 0);

        // R9 counter saturation on the narrow instance
        setup(200, 0, 1000);
        ctl(1'b1, 1'b0, 1'b1);
        wait_irq(700, got);
        chk("R9 window closed", int'(got), 1);
        tr_exp = model_step(tr_exp, 200, 0, 1000);
        repeat (100) @(negedge clk);
        chk("R9 narrow counter held at max", int'(s_count), 63);
        c1 = int'(live_count);
        chk("R3 wide counter keeps counting", c1, 101);
        @(negedge clk);
        chk("R9 narrow counter still at max", int'(s_count), 63);
        ctl(1'b0, 1'b0, 1'b1);
        chk("R4 trim after long window", int'(trim_code), tr_exp);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                total++;
                bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

endmodule